// File: doc/BRIEF.md
# eFuse array read controller

This block lets a host read bytes out of a one-time-programmable fuse array through a small set of memory-mapped registers. The host first loads read timing into a configuration register. It then writes a control word that gives a start address, a byte count and a half-select, with the read-enable bit set. It polls a completion flag and picks up as many as 32 bytes from eight 32-bit data registers.

On the array side, the controller presents one byte address at a time with the strobe low for a programmable setup time. It then raises the strobe for a programmable width and captures the byte the macro returns. After that it moves to the next address, until the requested count has been read. A behavioural model of the fuse macro sits inside the block. The model returns a fixed, address-derived byte pattern, so the read path can be exercised from end to end. Programming the array is not supported.

Top module: `efuse_rd_ctrl`

## Requirements
- R1: Register word offsets (byte address bits 5:2) are: control at 0, configuration at 1, status at 2, and data words 0..7 at 3..10. Any other offset reads as zero. Read data appears on `bus_rdata` one clock after `bus_rd` is sampled.
- R2: Control word layout: bit 30 is the half-select, bits 29:21 are the start address, bits 20:16 hold the byte count minus one, bit 15 is program enable, bit 1 is write enable and bit 0 is read enable. All other bits read as zero. Read enable reads back as 0 once a read has completed.
- R3: The configuration word keeps bit 31 (interrupt enable), bits 23:20 (read setup adjust `A`), bits 19:16 (read strobe `S`), bits 15:12 and bits 11:0. Bits 30:24 read as zero.
- R4: For each byte, `fz_strobe` stays low for A+1 clocks with the address already on `fz_addr`, then stays high for S+4 clocks with the address held. One byte therefore takes A+S+5 clocks.
- R5: Successive bytes use addresses base, base+1, and so on, for count+1 strobes. The address wraps modulo 512. `fz_cs` equals control bit 30 of the write that started the read.
- R6: Byte k of a read lands in data word k/4 at bits 8*(k%4)+7 : 8*(k%4) (little-endian). Data bytes beyond the count read as zero after the read.
- R7: Status bit 0 goes to 0 on the edge that accepts a start and goes to 1 on the edge that captures the last byte. Status bit 1 and all higher status bits always read as zero.
- R8: A write to the control register while a read is in progress has no effect. This includes a write on the very edge that captures the last byte.
- R9: A control write with program or write enable set but read enable clear produces no strobe, leaves the status unchanged and leaves the data words unchanged.
- R10: `irq` is high exactly while status bit 0 and configuration bit 31 are both 1.
- R11: The built-in fuse model returns, for half-select c and address a, the byte x[7:0] ^ {4{x[9:8]}} ^ 8'h3C, where x = {c, a}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 6 | Register byte address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Registered read data |
| irq | output | 1 | Read-complete interrupt |
| fz_cs | output | 1 | Fuse array upper-half select |
| fz_addr | output | 9 | Fuse array byte address |
| fz_strobe | output | 1 | Fuse array read strobe |

## Verification
The sharpest collision is a host control write that lands on the same clock edge as the capture of the final byte. On that edge the sequencer is still busy, but the completion flag and the read-enable clear are taking effect at the same moment. The bench counts the exact edge from A, S and the byte count, and drives a new start write to be sampled on that edge. It then judges the outcome at the pins and registers: the strobe stays low, the address and half-select hold their last values, the control readback keeps the old fields with read enable cleared, and the status shows completion.

// File: rtl/efuse_rd_pkg.sv
package efuse_rd_pkg;

  // register word offsets (byte address bits 5:2)
  localparam int unsigned REG_CTRL  = 0;
  localparam int unsigned REG_CFG   = 1;
  localparam int unsigned REG_STAT  = 2;
  localparam int unsigned REG_DATA0 = 3;

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_SETUP,
    SQ_STROBE
  } seq_state_e;

  // fixed fuse content used by the behavioural array model
  function automatic logic [7:0] fuse_pattern(input logic [9:0] x);
    return x[7:0] ^ {4{x[9:8]}} ^ 8'h3C;
  endfunction

endpackage

// File: rtl/efuse_array_model.sv
module efuse_array_model #(
  parameter int unsigned AW = 9
) (
  input  logic          clk,
  input  logic          cs,
  input  logic [AW-1:0] addr,
  input  logic          strobe,
  output logic [7:0]    rdata
);
  import efuse_rd_pkg::*;

  // synchronous read while strobed, like an inferred ROM port
  always_ff @(posedge clk) begin
    if (strobe) begin
      rdata <= fuse_pattern(10'({cs, addr}));
    end
  end

endmodule

// File: rtl/efuse_strobe_seq.sv
module efuse_strobe_seq #(
  parameter int unsigned AW   = 9,
  parameter int unsigned LENW = 5,
  parameter int unsigned ADJW = 4,
  parameter int unsigned STRW = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [AW-1:0]   start_addr,
  input  logic [LENW-1:0] len,
  input  logic [ADJW-1:0] rd_adj,
  input  logic [STRW-1:0] rd_str,
  input  logic [7:0]      fz_rdata,
  output logic            busy,
  output logic [AW-1:0]   fz_addr,
  output logic            fz_strobe,
  output logic            cap_valid,
  output logic [LENW-1:0] cap_idx,
  output logic [7:0]      cap_byte,
  output logic            fin
);
  import efuse_rd_pkg::*;

  localparam int unsigned CNTW = ((ADJW > STRW) ? ADJW : STRW) + 1;

  seq_state_e      state;
  logic [CNTW-1:0] cnt;
  logic [LENW-1:0] idx;
  logic [AW-1:0]   addr_q;
  logic            setup_end;
  logic            strobe_end;

  assign setup_end  = (state == SQ_SETUP)  && (cnt >= CNTW'(rd_adj));
  assign strobe_end = (state == SQ_STROBE) && (cnt >= CNTW'(rd_str) + CNTW'(3));

  assign busy      = (state != SQ_IDLE);
  assign fz_strobe = (state == SQ_STROBE);
  assign fz_addr   = addr_q;
  assign cap_valid = strobe_end;
  assign cap_idx   = idx;
  assign cap_byte  = fz_rdata;
  assign fin       = strobe_end && (idx == len);

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= SQ_IDLE;
      cnt    <= '0;
      idx    <= '0;
      addr_q <= '0;
    end else begin
      case (state)
        SQ_IDLE: begin
          if (start) begin
            state  <= SQ_SETUP;
            cnt    <= '0;
            idx    <= '0;
            addr_q <= start_addr;
          end
        end
        SQ_SETUP: begin
          if (setup_end) begin
            state <= SQ_STROBE;
            cnt   <= '0;
          end else begin
            cnt <= cnt + CNTW'(1);
          end
        end
        SQ_STROBE: begin
          if (strobe_end) begin
            cnt <= '0;
            if (idx == len) begin
              state <= SQ_IDLE;
            end else begin
              state  <= SQ_SETUP;
              idx    <= idx + LENW'(1);
              addr_q <= addr_q + AW'(1);
            end
          end else begin
            cnt <= cnt + CNTW'(1);
          end
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
    (fz_strobe && $past(fz_strobe)) |-> $stable(fz_addr)); // R4
  AST_STROBE_WIDTH: assert property (@(posedge clk) disable iff (rst)
    $fell(fz_strobe) |-> $past(fz_strobe, 4)); // R4

endmodule

// File: rtl/efuse_host_regs.sv
module efuse_host_regs #(
  parameter int unsigned AW     = 9,
  parameter int unsigned LENW   = 5,
  parameter int unsigned ADJW   = 4,
  parameter int unsigned STRW   = 4,
  parameter int unsigned BAW    = 6,
  parameter int unsigned NWORDS = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            bus_wr,
  input  logic            bus_rd,
  input  logic [BAW-1:0]  bus_addr,
  input  logic [31:0]     bus_wdata,
  output logic [31:0]     bus_rdata,
  input  logic            busy,
  input  logic            cap_valid,
  input  logic [LENW-1:0] cap_idx,
  input  logic [7:0]      cap_byte,
  input  logic            fin,
  output logic            start,
  output logic [AW-1:0]   start_addr,
  output logic [LENW-1:0] len,
  output logic            cs,
  output logic [ADJW-1:0] rd_adj,
  output logic [STRW-1:0] rd_str,
  output logic            done,
  output logic            irq
);
  import efuse_rd_pkg::*;

  localparam int unsigned WW  = BAW - 2;
  localparam int unsigned WIW = $clog2(NWORDS);

  logic [WW-1:0]   widx;
  logic            wr_ctrl;
  logic            wr_cfg;
  logic [AW-1:0]   ctl_addr;
  logic [LENW-1:0] ctl_len;
  logic            ctl_cs, ctl_pg, ctl_wr, ctl_rd;
  logic            cfg_ie;
  logic [ADJW-1:0] cfg_radj;
  logic [STRW-1:0] cfg_rstr;
  logic [3:0]      cfg_wadj;
  logic [11:0]     cfg_wstr;
  logic            rd_done;
  logic [31:0]     dbuf [NWORDS];
  logic [31:0]     rd_mux;
  logic [1:0]      unused_lo;

  assign unused_lo  = bus_addr[1:0];
  assign widx       = bus_addr[BAW-1:2];
  assign wr_ctrl    = bus_wr && (widx == WW'(REG_CTRL));
  assign wr_cfg     = bus_wr && (widx == WW'(REG_CFG));
  assign start      = wr_ctrl && !busy && bus_wdata[0];
  assign start_addr = bus_wdata[29:21];
  assign len        = ctl_len;
  assign cs         = ctl_cs;
  assign rd_adj     = cfg_radj;
  assign rd_str     = cfg_rstr;
  assign done       = rd_done;
  assign irq        = rd_done && cfg_ie;

  // control, configuration and status state
  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_addr <= '0;
      ctl_len  <= '0;
      ctl_cs   <= 1'b0;
      ctl_pg   <= 1'b0;
      ctl_wr   <= 1'b0;
      ctl_rd   <= 1'b0;
      cfg_ie   <= 1'b0;
      cfg_radj <= '0;
      cfg_rstr <= '0;
      cfg_wadj <= '0;
      cfg_wstr <= '0;
      rd_done  <= 1'b0;
    end else begin
      if (wr_ctrl && !busy) begin
        ctl_cs   <= bus_wdata[30];
        ctl_addr <= bus_wdata[29:21];
        ctl_len  <= bus_wdata[20:16];
        ctl_pg   <= bus_wdata[15];
        ctl_wr   <= bus_wdata[1];
        ctl_rd   <= bus_wdata[0];
      end else if (fin) begin
        ctl_rd <= 1'b0;
      end
      if (wr_cfg) begin
        cfg_ie   <= bus_wdata[31];
        cfg_radj <= bus_wdata[23:20];
        cfg_rstr <= bus_wdata[19:16];
        cfg_wadj <= bus_wdata[15:12];
        cfg_wstr <= bus_wdata[11:0];
      end
      if (start) begin
        rd_done <= 1'b0;
      end else if (fin) begin
        rd_done <= 1'b1;
      end
    end
  end

  // data buffer: one word per generate slice, cleared on every start
  for (genvar w = 0; w < NWORDS; w++) begin : g_word
    logic [31:0] word_q;
    always_ff @(posedge clk) begin
      if (rst || start) begin
        word_q <= '0;
      end else if (cap_valid && (cap_idx[LENW-1:2] == WIW'(w))) begin
        word_q[{cap_idx[1:0], 3'b000} +: 8] <= cap_byte;
      end
    end
    assign dbuf[w] = word_q;
  end

  always_comb begin
    rd_mux = '0;
    if (widx == WW'(REG_CTRL)) begin
      rd_mux = {1'b0, ctl_cs, ctl_addr, ctl_len, ctl_pg, 13'b0, ctl_wr, ctl_rd};
    end else if (widx == WW'(REG_CFG)) begin
      rd_mux = {cfg_ie, 7'b0, cfg_radj, cfg_rstr, cfg_wadj, cfg_wstr};
    end else if (widx == WW'(REG_STAT)) begin
      rd_mux = {30'b0, 1'b0, rd_done};
    end else if ((widx >= WW'(REG_DATA0)) && (widx < WW'(REG_DATA0 + NWORDS))) begin
      rd_mux = dbuf[WIW'(widx - WW'(REG_DATA0))];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      bus_rdata <= rd_mux;
    end
  end

  AST_DONE_FROM_FINISH: assert property (@(posedge clk) disable iff (rst)
    $rose(rd_done) |-> $past(fin)); // R7
  AST_CTRL_LOCK: assert property (@(posedge clk) disable iff (rst)
    busy |=> ($stable(ctl_addr) && $stable(ctl_len) && $stable(ctl_cs))); // R8

endmodule

// File: rtl/efuse_rd_ctrl.sv
module efuse_rd_ctrl #(
  parameter int unsigned AW   = 9,
  parameter int unsigned LENW = 5,
  parameter int unsigned ADJW = 4,
  parameter int unsigned STRW = 4,
  parameter int unsigned BAW  = 6
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           bus_wr,
  input  logic           bus_rd,
  input  logic [BAW-1:0] bus_addr,
  input  logic [31:0]    bus_wdata,
  output logic [31:0]    bus_rdata,
  output logic           irq,
  output logic           fz_cs,
  output logic [AW-1:0]  fz_addr,
  output logic           fz_strobe
);

  localparam int unsigned NWORDS = 2 ** (LENW - 2);

  logic            busy, start, cap_valid, fin, done;
  logic [AW-1:0]   start_addr;
  logic [LENW-1:0] len, cap_idx;
  logic [ADJW-1:0] rd_adj;
  logic [STRW-1:0] rd_str;
  logic [7:0]      cap_byte, fz_rdata;

  efuse_host_regs #(
    .AW(AW), .LENW(LENW), .ADJW(ADJW), .STRW(STRW), .BAW(BAW), .NWORDS(NWORDS)
  ) u_regs (
    .clk        (clk),
    .rst        (rst),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .busy       (busy),
    .cap_valid  (cap_valid),
    .cap_idx    (cap_idx),
    .cap_byte   (cap_byte),
    .fin        (fin),
    .start      (start),
    .start_addr (start_addr),
    .len        (len),
    .cs         (fz_cs),
    .rd_adj     (rd_adj),
    .rd_str     (rd_str),
    .done       (done),
    .irq        (irq)
  );

  efuse_strobe_seq #(
    .AW(AW), .LENW(LENW), .ADJW(ADJW), .STRW(STRW)
  ) u_seq (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .start_addr (start_addr),
    .len        (len),
    .rd_adj     (rd_adj),
    .rd_str     (rd_str),
    .fz_rdata   (fz_rdata),
    .busy       (busy),
    .fz_addr    (fz_addr),
    .fz_strobe  (fz_strobe),
    .cap_valid  (cap_valid),
    .cap_idx    (cap_idx),
    .cap_byte   (cap_byte),
    .fin        (fin)
  );

  efuse_array_model #(.AW(AW)) u_array (
    .clk    (clk),
    .cs     (fz_cs),
    .addr   (fz_addr),
    .strobe (fz_strobe),
    .rdata  (fz_rdata)
  );

  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (rst)
    done |-> !fz_strobe); // R7
  AST_CS_HOLD: assert property (@(posedge clk) disable iff (rst)
    fz_strobe |-> $stable(fz_cs)); // R5

endmodule

// File: tb/tb_efuse_rd_ctrl.sv
module tb_efuse_rd_ctrl;

  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq, fz_cs, fz_strobe;
  logic [8:0]  fz_addr;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  efuse_rd_ctrl dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .fz_cs(fz_cs),
    .fz_addr(fz_addr), .fz_strobe(fz_strobe)
  );

  // {adj[22:19], str[18:15], cs[14], addr[13:5], len[4:0]}
  localparam logic [22:0] VEC [6] = '{
    {4'd0,  4'd0,  1'b0, 9'h000, 5'd31},
    {4'd1,  4'd2,  1'b0, 9'h1FE, 5'd3},
    {4'd3,  4'd0,  1'b1, 9'h010, 5'd0},
    {4'd0,  4'd1,  1'b1, 9'h1F0, 5'd31},
    {4'd2,  4'd3,  1'b0, 9'h0A5, 5'd6},
    {4'd15, 4'd15, 1'b1, 9'h123, 5'd4}
  };

  function automatic logic [7:0] fz(input logic c, input logic [8:0] a);
    logic [9:0] x;
    x = {c, a};
    return x[7:0] ^ {4{x[9:8]}} ^ 8'h3C;
  endfunction

  function automatic logic [31:0] exp_word(input logic c, input logic [8:0] base,
                                           input logic [4:0] len, input int w);
    logic [31:0] r;
    r = '0;
    for (int l = 0; l < 4; l++) begin
      if (4 * w + l <= int'(len)) r[8*l +: 8] = fz(c, base + 9'(4 * w + l));
    end
    return r;
  endfunction

  function automatic logic [31:0] mk_ctrl(input logic c, input logic [8:0] a, input logic [4:0] n,
                                          input logic pg, input logic wr, input logic rd);
    return {1'b0, c, a, n, pg, 13'b0, wr, rd};
  endfunction

  function automatic logic [31:0] mk_cfg(input logic ie, input logic [3:0] adj, input logic [3:0] str);
    return {ie, 7'b0, adj, str, 16'b0};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bwr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic brd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic wait_done(output bit ok);
    logic [31:0] d;
    ok = 1'b0;
    for (int n = 0; n < 4000; n++) begin
      brd(6'h08, d);
      if (d[0]) begin ok = 1'b1; break; end
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] d;
    bit ok;

    repeat (5) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // reset state
    chk("R10 irq after reset", 32'(irq), 32'd0);
    chk("R4 strobe after reset", 32'(fz_strobe), 32'd0);
    brd(6'h00, d); chk("R2 ctrl after reset", d, 32'h0);
    brd(6'h08, d); chk("R7 status after reset", d, 32'h0);
    brd(6'h0C, d); chk("R6 data0 after reset", d, 32'h0);
    brd(6'h2C, d); chk("R1 unmapped offset", d, 32'h0);

    // configuration readback
    bwr(6'h04, 32'hFFFF_FFFF);
    brd(6'h04, d); chk("R3 cfg readback", d, 32'h80FF_FFFF);

    // table of reads
    for (int i = 0; i < 6; i++) begin
      logic [3:0] adj, str;
      logic       c;
      logic [8:0] a;
      logic [4:0] n;
      {adj, str, c, a, n} = VEC[i];
      bwr(6'h04, mk_cfg(1'b0, adj, str));
      bwr(6'h00, mk_ctrl(c, a, n, 1'b0, 1'b0, 1'b1));
      wait_done(ok);
      chk("R7 done reached", 32'(ok), 32'd1);
      brd(6'h00, d); chk("R2 ctrl readback rd cleared", d, mk_ctrl(c, a, n, 1'b0, 1'b0, 1'b0));
      for (int w = 0; w < 8; w++) begin
        brd(6'(12 + 4 * w), d);
        chk("R6 R5 R11 data word", d, exp_word(c, a, n, w));
      end
    end

    // strobe timing with A=2, S=1 (period 8), two bytes wrapping the address
    bwr(6'h04, mk_cfg(1'b0, 4'd2, 4'd1));
    bwr(6'h00, mk_ctrl(1'b1, 9'h1FF, 5'd1, 1'b0, 1'b0, 1'b1));
    chk("R4 strobe low after start", 32'(fz_strobe), 32'd0);
    chk("R5 first address", 32'(fz_addr), 32'h1FF);
    chk("R5 cs pin", 32'(fz_cs), 32'd1);
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R4 strobe low at end of setup", 32'(fz_strobe), 32'd0);
    @(negedge clk);
    chk("R4 strobe rises after A+1", 32'(fz_strobe), 32'd1);
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R4 strobe still high at S+4", 32'(fz_strobe), 32'd1);
    @(negedge clk);
    chk("R4 strobe low after period", 32'(fz_strobe), 32'd0);
    chk("R5 address wraps", 32'(fz_addr), 32'h000);

    // collision: new start write sampled on the final capture edge
    repeat (7) @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 6'h00; bus_wdata = mk_ctrl(1'b0, 9'h055, 5'd0, 1'b0, 1'b0, 1'b1);
    @(negedge clk);
    bus_wr = 1'b0;
    chk("R8 no strobe after collision", 32'(fz_strobe), 32'd0);
    chk("R8 address held", 32'(fz_addr), 32'h000);
    chk("R8 cs held", 32'(fz_cs), 32'd1);
    repeat (6) @(negedge clk);
    chk("R8 still no strobe", 32'(fz_strobe), 32'd0);
    brd(6'h08, d); chk("R7 done after collision", d, 32'h1);
    brd(6'h00, d); chk("R8 ctrl unchanged", d, mk_ctrl(1'b1, 9'h1FF, 5'd1, 1'b0, 1'b0, 1'b0));
    brd(6'h0C, d); chk("R6 R11 two-byte word", d, {16'h0, fz(1'b1, 9'h000), fz(1'b1, 9'h1FF)});

    // program / write enables only
    bwr(6'h00, mk_ctrl(1'b0, 9'h020, 5'd3, 1'b1, 1'b1, 1'b0));
    repeat (20) begin
      @(negedge clk);
      if (fz_strobe) chk("R9 strobe stays low", 32'd1, 32'd0);
    end
    chk("R9 strobe low", 32'(fz_strobe), 32'd0);
    brd(6'h08, d); chk("R9 status unchanged", d, 32'h1);
    brd(6'h0C, d); chk("R9 data unchanged", d, {16'h0, fz(1'b1, 9'h000), fz(1'b1, 9'h1FF)});
    brd(6'h00, d); chk("R2 pg wr readback", d, mk_ctrl(1'b0, 9'h020, 5'd3, 1'b1, 1'b1, 1'b0));

    // interrupt
    chk("R10 irq low with ie clear", 32'(irq), 32'd0);
    bwr(6'h04, mk_cfg(1'b1, 4'd0, 4'd0));
    chk("R10 irq high with done and ie", 32'(irq), 32'd1);
    bwr(6'h00, mk_ctrl(1'b0, 9'h040, 5'd2, 1'b0, 1'b0, 1'b1));
    chk("R10 irq drops on start", 32'(irq), 32'd0);
    brd(6'h08, d); chk("R7 done cleared by start", d, 32'h0);
    wait_done(ok);
    chk("R10 irq after completion", 32'(irq), 32'd1);
    bwr(6'h04, mk_cfg(1'b0, 4'd0, 4'd0));
    chk("R10 irq low after ie clear", 32'(irq), 32'd0);

    summary();
    $finish;
  end

endmodule